// File: doc/BRIEF.md
# Fractional-Predivide Clock Divider

This block derives one peripheral clock, for example a pixel clock or an audio master clock, from one of three reference clocks. The references are a crystal clock and two PLL outputs. A 16-bit configuration word picks the reference. It also sets a first-stage divide of 2, 2.5 or 3 and a second-stage integer divide of 2 to 127. The output period is the source period multiplied by both ratios, so the smallest overall ratio is 4.

The first stage works in half source periods and uses both edges of the selected clock, which makes the 2.5 setting exact. The second stage counts rising edges of the first-stage clock.

An enable bit inside the same word gates the whole chain. The word may only be rewritten while the enable bit is clear. A rewrite of the low 15 bits replaces every earlier setting. While the block is disabled, or while the word holds an illegal setting, the output stays low. When the block is enabled, the output starts with a clean rising edge followed by a full-length high phase.

Top module: `frac_clkdiv`

## Requirements
- R1: While cfg_word bit 15 (enable) is 0, clk_out is held low.
- R2: Bit 14 clear selects the crystal clock. Bit 14 set with bit 13 clear selects PLL1. Bits 14 and 13 both set select PLL2.
- R3: Bits 9:8 set the first-stage ratio. Code 1 gives 2, code 2 gives 2.5 and code 3 gives 3; the code equals twice the ratio minus 3.
- R4: Bits 6:0 hold the integer divide D (2..127). The clk_out period equals the source period times the first-stage ratio times D.
- R5: A first-stage code of 0 holds clk_out low even with the enable bit set.
- R6: An integer divide D of 0 or 1 holds clk_out low even with the enable bit set.
- R7: After enable, the first clk_out edge is rising. Every high phase, including the first, lasts floor(D/2) first-stage periods.
- R8: Bits 12:10 and bit 7 have no effect on the output.
- R9: A new word written while disabled fully replaces the previous source, ratio and divide.
- R10: While rst_n is low, clk_out is low. After release with an enabled legal word, the output runs at the programmed rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal reference clock |
| clk_pll1 | input | 1 | First PLL reference clock |
| clk_pll2 | input | 1 | Second PLL reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 16 | Enable, source select, first-stage code and integer divide |
| clk_out | output | 1 | Divided output clock |

## Verification
Two events can fall in the same cycle. The first-stage clock can take a transition on a falling source edge at the same moment the second-stage counter wraps and raises the output. With a 2.5 ratio and an odd divide, successive output edges land on alternating source-edge polarities. The bench provokes this by sweeping every source with all three ratios and the divides 2, 3, 64 and 127. It judges each case by measuring, in absolute time, the first high phase and two consecutive output periods against values computed from the requirement formulas. Between cases, a per-clock model of when the output must be low is checked on every crystal cycle.

// File: rtl/frac_clkdiv_pkg.sv
package frac_clkdiv_pkg;

   typedef enum logic [1:0] {
      SRC_XTAL = 2'd0,
      SRC_PLL1 = 2'd1,
      SRC_PLL2 = 2'd2
   } src_e;

   localparam int PRE_CODE_W = 2;
   localparam int HALF_W     = 3;

   // Two select bits map onto three sources; the PLL bit only matters when
   // the external bit is set.
   function automatic src_e src_decode(input logic ext_sel, input logic pll_sel);
      if (!ext_sel)     return SRC_XTAL;
      else if (pll_sel) return SRC_PLL2;
      else              return SRC_PLL1;
   endfunction

   // First-stage period in half source periods: code + 3 (4, 5 or 6).
   function automatic logic [HALF_W-1:0] halves_of(input logic [PRE_CODE_W-1:0] code);
      return HALF_W'(code) + HALF_W'(3);
   endfunction

   // One-step modulo, valid for v < 2*n.
   function automatic logic [HALF_W:0] wrap_once(input logic [HALF_W:0] v,
                                                 input logic [HALF_W-1:0] n);
      return (v >= {1'b0, n}) ? v - {1'b0, n} : v;
   endfunction

endpackage

// File: rtl/frac_clkdiv_src_mux.sv
module frac_clkdiv_src_mux
   import frac_clkdiv_pkg::*;
(
   input  logic clk_xtal,
   input  logic clk_pll1,
   input  logic clk_pll2,
   input  src_e sel,
   output logic src_clk
);

   // Static selection: the word only changes while the chain is held.
   always_comb begin
      unique case (sel)
         SRC_PLL1: src_clk = clk_pll1;
         SRC_PLL2: src_clk = clk_pll2;
         default:  src_clk = clk_xtal;
      endcase
   end

endmodule

// File: rtl/frac_clkdiv_sync.sv
module frac_clkdiv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("frac_clkdiv_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/frac_clkdiv_prediv.sv
module frac_clkdiv_prediv
   import frac_clkdiv_pkg::*;
(
   input  logic                  src_clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic [PRE_CODE_W-1:0] pre_code,
   output logic                  pre_clk
);

   logic [HALF_W-1:0] n_half;
   logic [HALF_W-1:0] h_half;
   logic [HALF_W-1:0] cyc;
   logic [HALF_W-1:0] cyc_nxt;
   logic [HALF_W:0]   pos_idx;
   logic [HALF_W:0]   neg_idx;
   logic              pos_hit;
   logic              neg_hit;
   logic              cyc_valid;
   logic              pos_t;
   logic              neg_t;

   assign n_half    = halves_of(pre_code);
   assign h_half    = n_half >> 1;
   assign cyc_valid = (cyc < n_half);
   assign cyc_nxt   = (cyc >= n_half - HALF_W'(1)) ? '0 : cyc + HALF_W'(1);

   // Half-period index of the rising edge that starts cycle cyc_nxt, and of
   // the falling edge in the middle of the current cycle, both modulo n_half.
   assign pos_idx = wrap_once({cyc_nxt, 1'b0}, n_half);
   assign neg_idx = wrap_once({cyc, 1'b1}, n_half);
   assign pos_hit = (pos_idx == '0) || (pos_idx == {1'b0, h_half});
   assign neg_hit = cyc_valid && ((neg_idx == '0) || (neg_idx == {1'b0, h_half}));

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc   <= '1;
         pos_t <= 1'b0;
      end else if (!run) begin
         cyc   <= '1;
         pos_t <= 1'b0;
      end else begin
         cyc <= cyc_nxt;
         if (pos_hit) pos_t <= ~pos_t;
      end
   end

   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n)       neg_t <= 1'b0;
      else if (!run)    neg_t <= 1'b0;
      else if (neg_hit) neg_t <= ~neg_t;
   end

   // Only one of the two toggles changes at any edge.
   assign pre_clk = pos_t ^ neg_t;

endmodule

// File: rtl/frac_clkdiv_post.sv
module frac_clkdiv_post #(
   parameter int DIV_W = 7
) (
   input  logic             pre_clk,
   input  logic             hold_n,
   input  logic [DIV_W-1:0] div_val,
   output logic [DIV_W-1:0] cnt_o,
   output logic             clk_out
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] cnt_nxt;
   logic [DIV_W-1:0] half;

   assign half    = div_val >> 1;
   assign cnt_nxt = (cnt >= div_val - DIV_W'(1)) ? '0 : cnt + DIV_W'(1);

   // Held state sits at all ones so the first enabled edge wraps to zero and
   // raises the output for a full high phase.
   always_ff @(posedge pre_clk or negedge hold_n) begin
      if (!hold_n) begin
         cnt     <= '1;
         clk_out <= 1'b0;
      end else begin
         cnt     <= cnt_nxt;
         clk_out <= (cnt_nxt < half);
      end
   end

   assign cnt_o = cnt;

endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv
   import frac_clkdiv_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int EN_BIT      = 15,
   parameter int EXT_BIT     = 14,
   parameter int PLL_BIT     = 13,
   parameter int PRE_LSB     = 8,
   parameter int DIV_LSB     = 0,
   parameter int DIV_W       = 7,
   parameter int MIN_DIV     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_xtal,
   input  logic             clk_pll1,
   input  logic             clk_pll2,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_word,
   output logic             clk_out
);

   localparam int PRE_MSB = PRE_LSB + PRE_CODE_W - 1;
   localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

   generate
      if (EN_BIT >= CFG_W || EXT_BIT >= CFG_W || PLL_BIT >= CFG_W || PRE_MSB >= CFG_W)
      begin : g_bad_pos
         $error("frac_clkdiv: a field lies outside the configuration word");
      end
      if (DIV_MSB >= PRE_LSB) begin : g_bad_overlap
         $error("frac_clkdiv: divide field overlaps the predivide field");
      end
      if (MIN_DIV < 2 || MIN_DIV >= (1 << DIV_W)) begin : g_bad_min
         $error("frac_clkdiv: MIN_DIV out of range");
      end
   endgenerate

   logic                  en_bit;
   logic [PRE_CODE_W-1:0] pre_code;
   logic [DIV_W-1:0]      div_val;
   logic                  cfg_legal;
   logic                  run_req;
   logic                  run_q;
   logic                  hold_n;
   src_e                  src_sel;
   logic                  src_clk;
   logic                  pre_clk;
   logic [DIV_W-1:0]      div_cnt;

   assign en_bit    = cfg_word[EN_BIT];
   assign pre_code  = cfg_word[PRE_MSB:PRE_LSB];
   assign div_val   = cfg_word[DIV_MSB:DIV_LSB];
   assign src_sel   = src_decode(cfg_word[EXT_BIT], cfg_word[PLL_BIT]);
   assign cfg_legal = (pre_code != '0) && (div_val >= DIV_W'(MIN_DIV));
   assign run_req   = en_bit && cfg_legal;

   frac_clkdiv_src_mux i_mux (
      .clk_xtal (clk_xtal),
      .clk_pll1 (clk_pll1),
      .clk_pll2 (clk_pll2),
      .sel      (src_sel),
      .src_clk  (src_clk)
   );

   frac_clkdiv_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (run_req),
      .q     (run_q)
   );

   frac_clkdiv_prediv i_pre (
      .src_clk  (src_clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .pre_code (pre_code),
      .pre_clk  (pre_clk)
   );

   assign hold_n = rst_n & run_q;

   frac_clkdiv_post #(.DIV_W(DIV_W)) i_post (
      .pre_clk (pre_clk),
      .hold_n  (hold_n),
      .div_val (div_val),
      .cnt_o   (div_cnt),
      .clk_out (clk_out)
   );

endmodule

// File: rtl/frac_clkdiv_chk.sv
module frac_clkdiv_chk #(
   parameter int DIV_W = 7
) (
   input logic             src_clk,
   input logic             pre_clk,
   input logic             rst_n,
   input logic             hold_n,
   input logic             run_q,
   input logic             en_bit,
   input logic [1:0]       pre_code,
   input logic [DIV_W-1:0] div_val,
   input logic [DIV_W-1:0] div_cnt,
   input logic             clk_out
);

   // Disabled for three source edges: output already forced low.
   assert_off_low_R1: assert property (@(posedge src_clk) disable iff (!rst_n)
      (!en_bit && $past(!en_bit) && $past(!en_bit, 2)) |-> !clk_out);

   assert_bad_pre_low_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
      (pre_code == 2'd0 && $past(pre_code == 2'd0) && $past(pre_code == 2'd0, 2))
      |-> !clk_out);

   assert_bad_div_low_R6: assert property (@(posedge src_clk) disable iff (!rst_n)
      (div_val < DIV_W'(2) && $past(div_val < DIV_W'(2)) && $past(div_val < DIV_W'(2), 2))
      |-> !clk_out);

   assert_rise_when_running_R7: assert property (@(posedge src_clk) disable iff (!rst_n)
      $rose(clk_out) |-> run_q);

   assert_count_range_R4: assert property (@(posedge pre_clk) disable iff (!hold_n)
      (div_cnt < div_val) || (&div_cnt));

endmodule

bind frac_clkdiv frac_clkdiv_chk #(.DIV_W(DIV_W)) i_chk (
   .src_clk  (src_clk),
   .pre_clk  (pre_clk),
   .rst_n    (rst_n),
   .hold_n   (hold_n),
   .run_q    (run_q),
   .en_bit   (en_bit),
   .pre_code (pre_code),
   .div_val  (div_val),
   .div_cnt  (div_cnt),
   .clk_out  (clk_out)
);

// File: tb/test_frac_clkdiv.sv
module test_frac_clkdiv;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk_xtal = 1'b0;
   logic        clk_pll1 = 1'b0;
   logic        clk_pll2 = 1'b0;
   logic        rst_n    = 1'b0;
   logic [15:0] cfg_word = '0;
   logic        clk_out;

   always #5 clk_xtal = ~clk_xtal;   // 100 MHz
   always #3 clk_pll1 = ~clk_pll1;
   always #2 clk_pll2 = ~clk_pll2;

   frac_clkdiv i_frac_clkdiv (
      .clk_xtal (clk_xtal),
      .clk_pll1 (clk_pll1),
      .clk_pll2 (clk_pll2),
      .rst_n    (rst_n),
      .cfg_word (cfg_word),
      .clk_out  (clk_out)
   );

   int    n_chk   = 0;
   int    n_fail  = 0;
   bit    exp_low = 1'b0;
   bit    done    = 1'b0;
   string low_tag = "R1";

   task automatic chk(input bit ok, input string req, input real act, input real exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   function automatic logic [15:0] mk(input bit en, input int src, input int pre,
                                      input int div, input bit junk);
      logic [15:0] w;
      w        = '0;
      w[15]    = en;
      w[14]    = (src != 0);
      w[13]    = (src == 2);
      w[12:10] = junk ? 3'b101 : 3'b000;
      w[9:8]   = pre[1:0];
      w[7]     = junk;
      w[6:0]   = div[6:0];
      return w;
   endfunction

   function automatic real tsrc(input int src);
      return (src == 0) ? 10.0 : (src == 1) ? 6.0 : 4.0;
   endfunction

   // Per-clock model: while the bench expects a held output, check every cycle.
   always @(negedge clk_xtal) begin
      if (exp_low) chk(clk_out == 1'b0, low_tag, real'(clk_out), 0.0);
   end

   task automatic go_idle();
      cfg_word[15] = 1'b0;
      #100;
      low_tag = "R1 disabled";
      exp_low = 1'b1;
      #200;
      exp_low = 1'b0;
   endtask

   task automatic run_case(input int src, input int pre, input int div,
                           input bit junk, input string tag);
      real half, t_pre, per, hi, t0, t1, t2, t3;
      half  = tsrc(src) / 2.0;
      t_pre = half * real'(pre + 3);
      per   = t_pre * real'(div);
      hi    = t_pre * real'(div / 2);
      go_idle();
      cfg_word = mk(1'b1, src, pre, div, junk);
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t2 = $realtime;
      @(posedge clk_out); t3 = $realtime;
      chk((t1 - t0 > hi - 0.001) && (t1 - t0 < hi + 0.001),
          $sformatf("R7 first high src%0d pre%0d div%0d %s", src, pre, div, tag), t1 - t0, hi);
      chk((t2 - t0 > per - 0.001) && (t2 - t0 < per + 0.001),
          $sformatf("R2/R3/R4 period src%0d pre%0d div%0d %s", src, pre, div, tag), t2 - t0, per);
      chk((t3 - t2 > per - 0.001) && (t3 - t2 < per + 0.001),
          $sformatf("R4 second period src%0d pre%0d div%0d %s", src, pre, div, tag), t3 - t2, per);
   endtask

   task automatic hold_case(input logic [15:0] w, input string tag);
      go_idle();
      cfg_word = w;
      #100;
      low_tag = tag;
      exp_low = 1'b1;
      #400;
      exp_low = 1'b0;
      chk(clk_out == 1'b0, tag, real'(clk_out), 0.0);
   endtask

   initial begin
      #1500000;
      chk(1'b0, "watchdog expired", 0.0, 1.0);
      finish_run();
   end

   initial begin
      real t0, t1;
      cfg_word = mk(1'b1, 0, 1, 2, 1'b0);
      #50;
      chk(clk_out == 1'b0, "R10 output low in reset", real'(clk_out), 0.0);
      #13 rst_n = 1'b1;
      @(posedge clk_out); t0 = $realtime;
      @(posedge clk_out); t1 = $realtime;
      chk((t1 - t0 > 39.999) && (t1 - t0 < 40.001), "R10 runs after reset", t1 - t0, 40.0);

      for (int src = 0; src < 3; src++) begin
         for (int pre = 1; pre <= 3; pre++) begin
            for (int k = 0; k < 4; k++) begin
               int div;
               div = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 64 : 127;
               run_case(src, pre, div, 1'b0, "sweep");
            end
         end
      end

      run_case(1, 2, 5, 1'b1, "R8 spare bits set");
      run_case(1, 2, 5, 1'b0, "R8 spare bits clear");

      hold_case(mk(1'b1, 1, 0, 10, 1'b0), "R5 predivide code 0");
      hold_case(mk(1'b1, 2, 2, 1, 1'b0), "R6 divide 1");
      hold_case(mk(1'b1, 0, 3, 0, 1'b0), "R6 divide 0");

      run_case(2, 3, 7, 1'b0, "R9 before rewrite");
      run_case(0, 2, 9, 1'b0, "R9 after rewrite");

      go_idle();
      finish_run();
   end

endmodule